// File: doc/BRIEF.md
# Link Rate Negotiation Controller

This block is the control half of a multi-rate Ethernet link. It decides the data rate the PCS runs at and when the PCS may carry traffic. The two link partners settle the rate by trading 16-bit channel-information words. Each side keeps sending its own word. Once the received word has held steady long enough, the controller takes the slower of the two advertised rates. It then idles the link for a programmable time and enables mission mode at that rate.

Three controls override negotiation. A bypass input places the PCS directly in mission mode at a rate given on a pin. A management hold input parks the controller in a held state. A restart input starts a fresh negotiation on its rising edge. The controller does not build ordered sets or fault messages. It only supplies the config word to send and three flags that tell the PCS what to transmit: config, idle or traffic.

Top module: `lnk_neg_ctrl`

## Requirements
- R1: During and right after circuit reset, `state_o` is 0 (held), `pcs_rate_o` is 3 (10G), and `mission_en_o` and `an_complete_o` are low.
- R2: Rate codes are 0=10M, 1=100M, 2=1G, 3=10G, 4=2.5G and 5=5G. A word advertises its rate in bits 11:9. The negotiated rate is whichever of the local and partner rates is slower.
- R3: While `main_reset_i` is high and bypass is low with negotiation enabled, the state is 0, `send_cfg_o` is high, `tx_word_o` is all zero, and the rate is forced to 10G one cycle after the hold is seen.
- R4: While `main_reset_i` is high and bypass is low with negotiation disabled, the state is 0, `send_idle_o` is high, and `pcs_rate_o` keeps its previous value.
- R5: When the hold is released, the controller goes to state 1 (restart) and then to state 2 (ability exchange) if negotiation is enabled. If negotiation is disabled, it goes to state 5 (link up without negotiation) with mission mode on at the kept rate.
- R6: In state 2, `tx_word_o` equals `adv_word_i` and `send_cfg_o` is high. The partner word is acknowledged on the third consecutive valid sample that carries an identical word. A different word starts the count again. Cycles without a valid sample neither add to the count nor break it.
- R7: After acknowledgment, state 3 holds `send_idle_o` high for exactly LINK_TICKS cycles. The next state is 4, with `mission_en_o`, `an_complete_o` and the negotiated rate all applied on the same edge.
- R8: A rising edge of `restart_i` while negotiation is enabled, bypass is low and the hold is low moves the state to 1 on the next edge, and mission mode and complete drop on that same edge. A level held high does not trigger again, and an edge while negotiation is disabled is ignored.
- R9: `bypass_i` high gives state 6, mission mode and `pcs_rate_o` equal to the `direct_rate_i` seen at the previous edge, whatever the hold and enable inputs are. When bypass is released, the controller behaves as in R5.
- R10: The inputs take effect in a fixed priority order: bypass, then the hold, then a restart edge, then progress through negotiation. A restart edge in the same cycle as an acknowledgment wins.
- R11: No more than one of `send_cfg_o`, `send_idle_o` and `mission_en_o` is high in any cycle, and `an_complete_o` is high only together with `mission_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low circuit reset |
| main_reset_i | input | 1 | Management hold of the negotiation |
| an_enable_i | input | 1 | Negotiation enable |
| restart_i | input | 1 | Restart request, acts on its rising edge |
| bypass_i | input | 1 | Skip negotiation and use the direct rate |
| direct_rate_i | input | 3 | Rate used under bypass |
| adv_word_i | input | WORD_W | Local channel-information word (rate in bits 11:9) |
| rx_word_i | input | WORD_W | Received partner word |
| rx_valid_i | input | 1 | Partner word valid strobe |
| tx_word_o | output | WORD_W | Config word to transmit |
| send_idle_o | output | 1 | PCS sends idles |
| send_cfg_o | output | 1 | PCS sends the config word |
| pcs_rate_o | output | 3 | Rate applied to the PCS |
| mission_en_o | output | 1 | PCS may carry traffic |
| state_o | output | 3 | Controller state code |
| an_complete_o | output | 1 | Negotiation completed |

## Verification
A restart edge can arrive in the same cycle as the third matching partner sample. Handling this case correctly depends entirely on the priority order. The bench holds back the third sample until it can drive it together with a fresh rising edge on the restart input. The next state must be restart (1), not the idle wait (3), and mission mode must stay low. A second collision is checked the same way: bypass is raised together with a restart edge, and the state must become 6.

// File: rtl/lnk_neg_pkg.sv
package lnk_neg_pkg;

  localparam int RATE_W   = 3;
  localparam int RATE_LSB = 9;

  typedef enum logic [2:0] {
    NS_HELD      = 3'd0,
    NS_RESTART   = 3'd1,
    NS_ABILITY   = 3'd2,
    NS_LINK_WAIT = 3'd3,
    NS_LINK_UP   = 3'd4,
    NS_DIS_UP    = 3'd5,
    NS_BYPASS    = 3'd6
  } neg_state_e;

  localparam logic [RATE_W-1:0] RATE_10M  = 3'd0;
  localparam logic [RATE_W-1:0] RATE_100M = 3'd1;
  localparam logic [RATE_W-1:0] RATE_1G   = 3'd2;
  localparam logic [RATE_W-1:0] RATE_10G  = 3'd3;
  localparam logic [RATE_W-1:0] RATE_2G5  = 3'd4;
  localparam logic [RATE_W-1:0] RATE_5G   = 3'd5;

  // Speed order of a rate code; unknown codes sort above every real rate.
  function automatic logic [2:0] rate_rank(input logic [RATE_W-1:0] code);
    logic [2:0] r;
    case (code)
      RATE_10M:  r = 3'd0;
      RATE_100M: r = 3'd1;
      RATE_1G:   r = 3'd2;
      RATE_2G5:  r = 3'd3;
      RATE_5G:   r = 3'd4;
      RATE_10G:  r = 3'd5;
      default:   r = 3'd6;
    endcase
    return r;
  endfunction

  // Slower of two rates; ties keep the local one.
  function automatic logic [RATE_W-1:0] slower_rate(input logic [RATE_W-1:0] loc,
                                                    input logic [RATE_W-1:0] far);
    return (rate_rank(far) < rate_rank(loc)) ? far : loc;
  endfunction

endpackage

// File: rtl/lnk_neg_edge.sv
module lnk_neg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic an_enable_i,
  input  logic bypass_i,
  input  logic main_reset_i,
  output logic restart_go
);

  logic restart_q;
  logic restart_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= restart_i;
  end

  assign restart_rise = restart_i & ~restart_q;
  assign restart_go   = restart_rise & an_enable_i & ~bypass_i & ~main_reset_i;

endmodule

// File: rtl/lnk_neg_match.sv
module lnk_neg_match #(
  parameter int WORD_W  = 16,
  parameter int SAMPLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              ack_hit
);

  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] prev_q;
  logic              same_word;

  assign same_word = (cnt_q != '0) && (rx_word_i == prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
    end else if (rx_valid_i) begin
      prev_q <= rx_word_i;
      if (same_word) cnt_q <= (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
      else           cnt_q <= CNT_W'(1);
    end
  end

  assign ack_hit = ~clear_i & rx_valid_i & same_word & (cnt_q == LAST);

endmodule

// File: rtl/lnk_neg_timer.sv
module lnk_neg_timer #(
  parameter int LINK_TICKS = 1600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic timer_done
);

  localparam int CNT_W = $clog2(LINK_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINK_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign timer_done = run_i & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (run_i && !timer_done) cnt_q <= cnt_q + 1'b1;
    else                           cnt_q <= '0;
  end

endmodule

// File: rtl/lnk_neg_ctrl.sv
module lnk_neg_ctrl
  import lnk_neg_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int LINK_TICKS  = 1600000,
  parameter int ACK_SAMPLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_reset_i,
  input  logic              an_enable_i,
  input  logic              restart_i,
  input  logic              bypass_i,
  input  logic [2:0]        direct_rate_i,
  input  logic [WORD_W-1:0] adv_word_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              send_idle_o,
  output logic              send_cfg_o,
  output logic [2:0]        pcs_rate_o,
  output logic              mission_en_o,
  output logic [2:0]        state_o,
  output logic              an_complete_o
);

  neg_state_e        state_q, state_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [RATE_W-1:0] pend_q, pend_d;
  logic              restart_go;
  logic              ack_hit;
  logic              timer_done;
  logic              en_eff;
  logic              in_ability;
  logic              in_wait;
  logic [RATE_W-1:0] local_rate;
  logic [RATE_W-1:0] far_rate;

  assign en_eff     = an_enable_i & ~bypass_i;
  assign in_ability = (state_q == NS_ABILITY);
  assign in_wait    = (state_q == NS_LINK_WAIT);
  assign local_rate = adv_word_i[RATE_LSB +: RATE_W];
  assign far_rate   = rx_word_i[RATE_LSB +: RATE_W];

  lnk_neg_edge i_edge (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart_i    (restart_i),
    .an_enable_i  (an_enable_i),
    .bypass_i     (bypass_i),
    .main_reset_i (main_reset_i),
    .restart_go   (restart_go)
  );

  lnk_neg_match #(.WORD_W(WORD_W), .SAMPLES(ACK_SAMPLES)) i_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (~in_ability),
    .rx_valid_i (rx_valid_i),
    .rx_word_i  (rx_word_i),
    .ack_hit    (ack_hit)
  );

  lnk_neg_timer #(.LINK_TICKS(LINK_TICKS)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (in_wait),
    .timer_done (timer_done)
  );

  // Priority: bypass, hold, restart edge, then negotiation progress.
  always_comb begin
    state_d = state_q;
    rate_d  = rate_q;
    pend_d  = pend_q;
    if (bypass_i) begin
      state_d = NS_BYPASS;
      rate_d  = direct_rate_i;
    end else if (main_reset_i) begin
      state_d = NS_HELD;
      if (an_enable_i) rate_d = RATE_10G;
    end else if (restart_go) begin
      state_d = NS_RESTART;
    end else begin
      case (state_q)
        NS_HELD, NS_BYPASS: state_d = an_enable_i ? NS_RESTART : NS_DIS_UP;
        NS_RESTART:         state_d = NS_ABILITY;
        NS_ABILITY: begin
          if (ack_hit) begin
            state_d = NS_LINK_WAIT;
            pend_d  = slower_rate(local_rate, far_rate);
          end
        end
        NS_LINK_WAIT: begin
          if (timer_done) begin
            state_d = NS_LINK_UP;
            rate_d  = pend_q;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NS_HELD;
      rate_q  <= RATE_10G;
      pend_q  <= RATE_10G;
    end else begin
      state_q <= state_d;
      rate_q  <= rate_d;
      pend_q  <= pend_d;
    end
  end

  assign send_cfg_o    = ((state_q == NS_HELD) && en_eff) ||
                         (state_q == NS_RESTART) || in_ability;
  assign send_idle_o   = ((state_q == NS_HELD) && !en_eff) || in_wait;
  assign tx_word_o     = in_ability ? adv_word_i : '0;
  assign mission_en_o  = (state_q == NS_LINK_UP) || (state_q == NS_DIS_UP) ||
                         (state_q == NS_BYPASS);
  assign an_complete_o = (state_q == NS_LINK_UP);
  assign pcs_rate_o    = rate_q;
  assign state_o       = state_q;

endmodule

// File: rtl/lnk_neg_chk.sv
module lnk_neg_chk #(
  parameter int WORD_W     = 16,
  parameter int LINK_TICKS = 1600000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              main_reset_i,
  input logic              an_enable_i,
  input logic              restart_i,
  input logic              bypass_i,
  input logic [2:0]        direct_rate_i,
  input logic [WORD_W-1:0] tx_word_o,
  input logic              send_idle_o,
  input logic              send_cfg_o,
  input logic [2:0]        pcs_rate_o,
  input logic              mission_en_o,
  input logic [2:0]        state_o,
  input logic              an_complete_o,
  input logic              restart_go,
  input logic              ack_hit,
  input logic              timer_done
);

  logic [31:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_cnt <= '0;
    else if (state_o == 3'd3) wait_cnt <= wait_cnt + 1'b1;
    else                     wait_cnt <= '0;
  end

  assert_hold_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_reset_i && an_enable_i && !bypass_i) |=> (state_o == 3'd0 && pcs_rate_o == 3'd3));

  assert_hold_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && an_enable_i && !bypass_i) |-> (send_cfg_o && tx_word_o == '0));

  assert_hold_keep_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && main_reset_i && !an_enable_i && !bypass_i) |=> $stable(pcs_rate_o));

  assert_ack_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !bypass_i && !main_reset_i && !restart_go) |=> (state_o == 3'd3 && send_idle_o));

  assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) |-> (wait_cnt < LINK_TICKS));

  assert_wait_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd3 && state_o == 3'd4) |-> ($past(wait_cnt) == LINK_TICKS - 1));

  assert_timer_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_done && !bypass_i && !main_reset_i && !restart_go) |=> (state_o == 3'd4 && an_complete_o));

  assert_restart_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_go) |=> (state_o == 3'd1 && !mission_en_o && !an_complete_o));

  assert_restart_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && restart_i && $past(restart_i) && !bypass_i && !main_reset_i) |=> (state_o == 3'd4));

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> (state_o == 3'd6 && mission_en_o && pcs_rate_o == $past(direct_rate_i)));

  assert_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_cfg_o, send_idle_o, mission_en_o}));

  assert_complete_R11: assert property (@(posedge clk) disable iff (!rst_n)
    an_complete_o |-> mission_en_o);

endmodule

bind lnk_neg_ctrl lnk_neg_chk #(.WORD_W(WORD_W), .LINK_TICKS(LINK_TICKS)) i_lnk_neg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .main_reset_i  (main_reset_i),
  .an_enable_i   (an_enable_i),
  .restart_i     (restart_i),
  .bypass_i      (bypass_i),
  .direct_rate_i (direct_rate_i),
  .tx_word_o     (tx_word_o),
  .send_idle_o   (send_idle_o),
  .send_cfg_o    (send_cfg_o),
  .pcs_rate_o    (pcs_rate_o),
  .mission_en_o  (mission_en_o),
  .state_o       (state_o),
  .an_complete_o (an_complete_o),
  .restart_go    (restart_go),
  .ack_hit       (ack_hit),
  .timer_done    (timer_done)
);

// File: tb/test_lnk_neg_ctrl.sv
module test_lnk_neg_ctrl;

  localparam int T = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        main_reset_i = 1'b1;
  logic        an_enable_i = 1'b1;
  logic        restart_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic [2:0]  direct_rate_i = 3'd0;
  logic [15:0] adv_word_i = 16'h0;
  logic [15:0] rx_word_i = 16'h0;
  logic        rx_valid_i = 1'b0;
  logic [15:0] tx_word_o;
  logic        send_idle_o, send_cfg_o, mission_en_o, an_complete_o;
  logic [2:0]  pcs_rate_o, state_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [2:0] cur_rate;

  always #2 clk = ~clk;

  lnk_neg_ctrl #(.WORD_W(16), .LINK_TICKS(T), .ACK_SAMPLES(3)) i_lnk_neg_ctrl (
    .clk(clk), .rst_n(rst_n), .main_reset_i(main_reset_i), .an_enable_i(an_enable_i),
    .restart_i(restart_i), .bypass_i(bypass_i), .direct_rate_i(direct_rate_i),
    .adv_word_i(adv_word_i), .rx_word_i(rx_word_i), .rx_valid_i(rx_valid_i),
    .tx_word_o(tx_word_o), .send_idle_o(send_idle_o), .send_cfg_o(send_cfg_o),
    .pcs_rate_o(pcs_rate_o), .mission_en_o(mission_en_o), .state_o(state_o),
    .an_complete_o(an_complete_o));

  function automatic int speed_mbps(input logic [2:0] c);
    case (c)
      3'd0: return 10;
      3'd1: return 100;
      3'd2: return 1000;
      3'd4: return 2500;
      3'd5: return 5000;
      3'd3: return 10000;
      default: return 99999;
    endcase
  endfunction

  function automatic logic [2:0] expect_rate(input logic [2:0] a, input logic [2:0] b);
    return (speed_mbps(b) < speed_mbps(a)) ? b : a;
  endfunction

  function automatic logic [15:0] with_rate(input logic [15:0] w, input logic [2:0] r);
    logic [15:0] x;
    x = w;
    x[11:9] = r;
    return x;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Enters with the controller in state 2; ends in state 4.
  task automatic run_ability(input logic [15:0] partner, input bit junk_first);
    logic [2:0] exp_r;
    exp_r = expect_rate(adv_word_i[11:9], partner[11:9]);
    chk("R6 ability state", state_o, 2);
    chk("R6 tx word", tx_word_o, adv_word_i);
    chk("R6 send cfg", send_cfg_o, 1);
    if (junk_first) begin
      rx_valid_i = 1'b1; rx_word_i = partner ^ 16'h0001;
      step();
      chk("R6 junk no ack", state_o, 2);
    end
    for (int k = 0; k < 3; k++) begin
      if ($urandom_range(0, 1) == 1) begin
        rx_valid_i = 1'b0; rx_word_i = $urandom();
        step();
        chk("R6 gap no ack", state_o, 2);
      end
      rx_valid_i = 1'b1; rx_word_i = partner;
      step();
      if (k < 2) chk("R6 early no ack", state_o, 2);
      else begin
        chk("R7 idle wait state", state_o, 3);
        chk("R7 send idle", send_idle_o, 1);
      end
    end
    rx_valid_i = 1'b0;
    repeat (T - 1) step();
    chk("R7 still waiting", state_o, 3);
    chk("R7 rate not yet applied", pcs_rate_o, cur_rate);
    step();
    chk("R7 link up", state_o, 4);
    chk("R7 mission", mission_en_o, 1);
    chk("R7 complete", an_complete_o, 1);
    chk("R2 resolved rate", pcs_rate_o, exp_r);
    chk("R11 no cfg in mission", send_cfg_o, 0);
    cur_rate = exp_r;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] partner;
    logic [2:0]  r;
    void'($urandom(32'd4711));
    @(negedge clk);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset rate", pcs_rate_o, 3);
    chk("R1 reset mission", mission_en_o, 0);
    chk("R1 reset complete", an_complete_o, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R3 held state", state_o, 0);
    chk("R3 send cfg", send_cfg_o, 1);
    chk("R3 zero word", tx_word_o, 0);
    chk("R3 rate 10G", pcs_rate_o, 3);
    cur_rate = 3'd3;

    // First negotiation: 5G local against 1G partner.
    adv_word_i = with_rate(16'hA05B, 3'd5);
    main_reset_i = 1'b0;
    step();
    chk("R5 restart after release", state_o, 1);
    chk("R5 no mission", mission_en_o, 0);
    step();
    run_ability(with_rate(16'h1234, 3'd2), 1'b1);

    // Restart edge, level held; broken run of samples.
    restart_i = 1'b1;
    step();
    chk("R8 restart state", state_o, 1);
    chk("R8 mission cleared", mission_en_o, 0);
    chk("R8 complete cleared", an_complete_o, 0);
    step();
    step();
    chk("R8 level no retrigger", state_o, 2);
    partner = with_rate(16'h5A5A, 3'd0);
    rx_valid_i = 1'b1; rx_word_i = partner; step();
    rx_word_i = partner; step();
    rx_word_i = partner ^ 16'h8000; step();
    chk("R6 broken run", state_o, 2);
    restart_i = 1'b0;
    run_ability(partner, 1'b0);

    // Random negotiations.
    for (int t = 0; t < 30; t++) begin
      adv_word_i = with_rate(16'($urandom()), 3'($urandom_range(0, 5)));
      partner    = with_rate(16'($urandom()), 3'($urandom_range(0, 5)));
      restart_i = 1'b1; step();
      chk("R8 random restart", state_o, 1);
      restart_i = 1'b0; step();
      run_ability(partner, 1'($urandom_range(0, 1)));
    end

    // Collision: restart edge with the third matching sample.
    restart_i = 1'b1; step();
    restart_i = 1'b0; step();
    partner = with_rate(16'h0F0F, 3'd1);
    rx_valid_i = 1'b1; rx_word_i = partner; step();
    step();
    chk("R10 two samples no ack", state_o, 2);
    restart_i = 1'b1; step();
    chk("R10 restart beats ack", state_o, 1);
    chk("R10 no mission", mission_en_o, 0);
    rx_valid_i = 1'b0; restart_i = 1'b0; step();
    chk("R5 ability again", state_o, 2);

    // Hold with negotiation disabled.
    an_enable_i = 1'b0; main_reset_i = 1'b1; step();
    chk("R4 held state", state_o, 0);
    chk("R4 send idle", send_idle_o, 1);
    chk("R4 no cfg", send_cfg_o, 0);
    chk("R4 rate kept", pcs_rate_o, cur_rate);
    main_reset_i = 1'b0; step();
    chk("R5 disabled link up", state_o, 5);
    chk("R5 mission", mission_en_o, 1);
    chk("R5 rate kept", pcs_rate_o, cur_rate);
    chk("R11 complete low", an_complete_o, 0);
    restart_i = 1'b1; step();
    chk("R8 ignored when disabled", state_o, 5);
    restart_i = 1'b0; step();

    // Bypass over hold and enable.
    r = 3'($urandom_range(0, 5));
    bypass_i = 1'b1; main_reset_i = 1'b1; an_enable_i = 1'b1; direct_rate_i = r; step();
    chk("R9 bypass state", state_o, 6);
    chk("R9 bypass mission", mission_en_o, 1);
    chk("R9 bypass rate", pcs_rate_o, r);
    direct_rate_i = r ^ 3'd1; step();
    chk("R9 rate follows", pcs_rate_o, r ^ 3'd1);
    bypass_i = 1'b0; step();
    chk("R10 hold after bypass", state_o, 0);
    chk("R3 rate forced", pcs_rate_o, 3);
    main_reset_i = 1'b0; step();
    chk("R5 restart after hold", state_o, 1);
    bypass_i = 1'b1; direct_rate_i = 3'd4; step();
    bypass_i = 1'b0; an_enable_i = 1'b0; step();
    chk("R9 release disabled", state_o, 5);
    chk("R9 rate kept", pcs_rate_o, 4);
    an_enable_i = 1'b1; bypass_i = 1'b1; restart_i = 1'b1; direct_rate_i = 3'd1; step();
    chk("R10 bypass beats restart", state_o, 6);
    chk("R10 bypass rate", pcs_rate_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule